// File: doc/BRIEF.md
# Streaming Mode State Controller

This block holds the two architectural flags of a streaming execution mode: a streaming flag and an enable for the two-dimensional tile storage. It also owns the scalable vector and predicate register files that the streaming mode reshapes. Start and stop commands drive the flags. Each command may carry a streaming selector and an array selector. A command with neither selector set acts on both flags. A command with one or both selectors set acts only on the selected flags.

When the streaming flag actually changes value, in either direction, the whole vector and predicate state is wiped. This includes the narrow legacy SIMD view made of the low 128 bits of each vector register. The wipe takes one cycle, and a busy flag shows it. Register writes are back-pressured through their valid/ready handshakes while busy is high. A write transfers only on a cycle where both valid and ready are high, and ready depends only on busy, never on valid.

An instruction-class check port reports, combinationally, whether the class presented is illegal in the current state. Legacy SIMD is illegal while streaming, unless the full-ISA option input is high. Tile storage access is illegal while the array is disabled. When the array is disabled, a one-cycle request to zero the tile storage is raised.

Top module: `smode_ctrl`

## Requirements
- R1: After reset the streaming flag, array enable, busy and zero request are all 0, and every vector, predicate and legacy read returns 0.
- R2: A command (cmd_stop=0 start, 1 stop) with both selectors low sets (start) or clears (stop) both the streaming flag and the array enable, visible the cycle after the command.
- R3: With a selector set, only the selected flag follows the command; the other flag keeps its value.
- R4: A command that changes the streaming flag raises busy for exactly the following cycle; vw_ready and pw_ready are low whenever busy is high, and high otherwise.
- R5: From the busy cycle onward after a streaming change, every vector, predicate and legacy read returns 0 until that register is written again.
- R6: A command that leaves the streaming flag unchanged (start while streaming, stop while not) raises no busy and leaves all register contents intact.
- R7: A write accepted on a clock edge is returned by the matching read port from the next cycle; lr_data returns bits 127:0 of the vector register addressed by lr_addr.
- R8: With chk_valid high and class 1 (legacy SIMD), chk_illegal is high exactly when streaming is on and full_isa is low.
- R9: With chk_valid high, class 3 (tile access) is illegal exactly when the array is disabled; classes 0 (base) and 2 (scalable vector) are never illegal; chk_illegal is 0 when chk_valid is low.
- R10: A command that turns the array enable from 1 to 0 makes za_zero_req high for exactly the following cycle; it is 0 otherwise.
- R11: A write presented while its ready is low does not change the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_stop | input | 1 | 0 start, 1 stop |
| cmd_sel_sm | input | 1 | Streaming selector |
| cmd_sel_za | input | 1 | Array selector |
| full_isa | input | 1 | Allows legacy SIMD while streaming |
| chk_valid | input | 1 | Class check strobe |
| chk_class | input | 2 | 0 base, 1 legacy SIMD, 2 scalable vector, 3 tile access |
| chk_illegal | output | 1 | Class is illegal in current state |
| vw_valid | input | 1 | Vector write valid |
| vw_ready | output | 1 | Vector write ready |
| vw_addr | input | 5 | Vector write register |
| vw_data | input | 512 | Vector write data |
| pw_valid | input | 1 | Predicate write valid |
| pw_ready | output | 1 | Predicate write ready |
| pw_addr | input | 4 | Predicate write register |
| pw_data | input | 64 | Predicate write data |
| vr_addr | input | 5 | Vector read register |
| vr_data | output | 512 | Vector read data |
| pr_addr | input | 4 | Predicate read register |
| pr_data | output | 64 | Predicate read data |
| lr_addr | input | 5 | Legacy view read register |
| lr_data | output | 128 | Legacy view read data |
| in_stream | output | 1 | Streaming flag |
| array_en | output | 1 | Tile array enable |
| busy | output | 1 | Wipe in progress |
| za_zero_req | output | 1 | Tile storage zero request |

## Verification
A stale liveness bit would show up as old data on a read port in the cycle after a streaming change, or on the first read after it. A missed wipe would stay visible until that register is written again. A wrong flag shows at once in the legality result for legacy SIMD or tile classes, and on the flag outputs one cycle after the command. A busy or ready that is out of step would let a write through that should have been lost, or drop one that should have been kept. That shows at the read port one cycle later.

// File: rtl/smode_pkg.sv
package smode_pkg;
  typedef enum logic [1:0] {
    CLS_BASE   = 2'd0,
    CLS_LEGACY = 2'd1,
    CLS_VEC    = 2'd2,
    CLS_TILE   = 2'd3
  } iclass_e;
endpackage

// File: rtl/smode_state.sv
module smode_state (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_valid,
  input  logic cmd_stop,
  input  logic cmd_sel_sm,
  input  logic cmd_sel_za,
  output logic in_stream,
  output logic array_en,
  output logic busy,
  output logic za_zero_req
);
  logic apply_sm, apply_za, target, sm_flip, za_fall;

  // no selectors means both flags are addressed
  assign apply_sm = cmd_sel_sm | ~cmd_sel_za;
  assign apply_za = cmd_sel_za | ~cmd_sel_sm;
  assign target   = ~cmd_stop;
  assign sm_flip  = cmd_valid & apply_sm & (in_stream != target);
  assign za_fall  = cmd_valid & apply_za & array_en & ~target;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_stream   <= 1'b0;
      array_en    <= 1'b0;
      busy        <= 1'b0;
      za_zero_req <= 1'b0;
    end else begin
      if (cmd_valid && apply_sm) in_stream <= target;
      if (cmd_valid && apply_za) array_en  <= target;
      busy        <= sm_flip;
      za_zero_req <= za_fall;
    end
  end
endmodule

// File: rtl/smode_legal.sv
module smode_legal
  import smode_pkg::*;
(
  input  logic       chk_valid,
  input  logic [1:0] chk_class,
  input  logic       in_stream,
  input  logic       array_en,
  input  logic       full_isa,
  output logic       chk_illegal
);
  iclass_e cls;
  assign cls = iclass_e'(chk_class);

  always_comb begin
    chk_illegal = 1'b0;
    if (chk_valid) begin
      unique case (cls)
        CLS_LEGACY: chk_illegal = in_stream & ~full_isa;
        CLS_TILE:   chk_illegal = ~array_en;
        default:    chk_illegal = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/smode_regfile.sv
module smode_regfile #(
  parameter int DEPTH    = 32,
  parameter int WIDTH    = 512,
  parameter int RD_PORTS = 1,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr [RD_PORTS],
  output logic [WIDTH-1:0] rdata [RD_PORTS]
);
  logic [WIDTH-1:0] mem  [DEPTH];
  logic [DEPTH-1:0] live;

  // data array holds no reset; liveness bits make a wipe a single-cycle event
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) live <= '0;
    else if (we)         live[waddr] <= 1'b1;
  end

  for (genvar g = 0; g < RD_PORTS; g++) begin : g_rd
    assign rdata[g] = live[raddr[g]] ? mem[raddr[g]] : '0;
  end
endmodule

// File: rtl/smode_ctrl.sv
module smode_ctrl #(
  parameter int VEC_BYTES   = 64,
  parameter int NUM_VREG    = 32,
  parameter int NUM_PREG    = 16,
  parameter int LEGACY_BITS = 128,
  localparam int VW  = VEC_BYTES * 8,
  localparam int PW  = VEC_BYTES,
  localparam int VAW = $clog2(NUM_VREG),
  localparam int PAW = $clog2(NUM_PREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_stop,
  input  logic             cmd_sel_sm,
  input  logic             cmd_sel_za,
  input  logic             full_isa,
  input  logic             chk_valid,
  input  logic [1:0]       chk_class,
  output logic             chk_illegal,
  input  logic             vw_valid,
  output logic             vw_ready,
  input  logic [VAW-1:0]   vw_addr,
  input  logic [VW-1:0]    vw_data,
  input  logic             pw_valid,
  output logic             pw_ready,
  input  logic [PAW-1:0]   pw_addr,
  input  logic [PW-1:0]    pw_data,
  input  logic [VAW-1:0]   vr_addr,
  output logic [VW-1:0]    vr_data,
  input  logic [PAW-1:0]   pr_addr,
  output logic [PW-1:0]    pr_data,
  input  logic [VAW-1:0]   lr_addr,
  output logic [LEGACY_BITS-1:0] lr_data,
  output logic             in_stream,
  output logic             array_en,
  output logic             busy,
  output logic             za_zero_req
);
  logic           v_we, p_we;
  logic [VAW-1:0] v_ra [2];
  logic [VW-1:0]  v_rd [2];
  logic [PAW-1:0] p_ra [1];
  logic [PW-1:0]  p_rd [1];
  logic           unused_hi;

  smode_state i_state (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_stop(cmd_stop),
    .cmd_sel_sm(cmd_sel_sm), .cmd_sel_za(cmd_sel_za),
    .in_stream(in_stream), .array_en(array_en),
    .busy(busy), .za_zero_req(za_zero_req)
  );

  smode_legal i_legal (
    .chk_valid(chk_valid), .chk_class(chk_class),
    .in_stream(in_stream), .array_en(array_en),
    .full_isa(full_isa), .chk_illegal(chk_illegal)
  );

  assign vw_ready = ~busy;
  assign pw_ready = ~busy;
  assign v_we     = vw_valid & vw_ready;
  assign p_we     = pw_valid & pw_ready;
  assign v_ra[0]  = vr_addr;
  assign v_ra[1]  = lr_addr;
  assign p_ra[0]  = pr_addr;

  smode_regfile #(.DEPTH(NUM_VREG), .WIDTH(VW), .RD_PORTS(2)) i_vrf (
    .clk(clk), .rst_n(rst_n), .clear(busy),
    .we(v_we), .waddr(vw_addr), .wdata(vw_data),
    .raddr(v_ra), .rdata(v_rd)
  );

  smode_regfile #(.DEPTH(NUM_PREG), .WIDTH(PW), .RD_PORTS(1)) i_prf (
    .clk(clk), .rst_n(rst_n), .clear(busy),
    .we(p_we), .waddr(pw_addr), .wdata(pw_data),
    .raddr(p_ra), .rdata(p_rd)
  );

  // during the wipe cycle the state is already architecturally zero
  assign vr_data   = busy ? '0 : v_rd[0];
  assign pr_data   = busy ? '0 : p_rd[0];
  assign lr_data   = busy ? '0 : v_rd[1][LEGACY_BITS-1:0];
  assign unused_hi = ^v_rd[1][VW-1:LEGACY_BITS];
endmodule

// File: rtl/smode_ctrl_chk.sv
module smode_ctrl_chk #(
  parameter int VW = 512,
  parameter int PW = 64,
  parameter int LB = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_stop,
  input logic          cmd_sel_sm,
  input logic          cmd_sel_za,
  input logic          full_isa,
  input logic          chk_valid,
  input logic [1:0]    chk_class,
  input logic          chk_illegal,
  input logic          vw_ready,
  input logic          pw_ready,
  input logic [VW-1:0] vr_data,
  input logic [PW-1:0] pr_data,
  input logic [LB-1:0] lr_data,
  input logic          in_stream,
  input logic          array_en,
  input logic          busy,
  input logic          za_zero_req
);
  // R2
  start_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_stop && !cmd_sel_sm && !cmd_sel_za |=> in_stream && array_en);
  // R3
  sel_za_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_sel_za && !cmd_sel_sm |=> $stable(in_stream));
  // R4
  busy_after_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (cmd_sel_sm || !cmd_sel_za) && (cmd_stop == in_stream) |=> busy);
  // R4
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !vw_ready && !pw_ready);
  // R5
  wipe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> vr_data == '0 && pr_data == '0 && lr_data == '0);
  // R6
  no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_stop && in_stream |=> !busy);
  // R8
  legacy_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && chk_class == 2'd1 && in_stream && !full_isa |-> chk_illegal);
  // R9
  tile_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && chk_class == 2'd3 && !array_en |-> chk_illegal);
  // R10
  zero_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(array_en) |-> za_zero_req);
endmodule

bind smode_ctrl smode_ctrl_chk #(.VW(VW), .PW(PW), .LB(LEGACY_BITS)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_stop(cmd_stop),
  .cmd_sel_sm(cmd_sel_sm), .cmd_sel_za(cmd_sel_za), .full_isa(full_isa),
  .chk_valid(chk_valid), .chk_class(chk_class), .chk_illegal(chk_illegal),
  .vw_ready(vw_ready), .pw_ready(pw_ready), .vr_data(vr_data),
  .pr_data(pr_data), .lr_data(lr_data), .in_stream(in_stream),
  .array_en(array_en), .busy(busy), .za_zero_req(za_zero_req)
);

// File: tb/test_smode_ctrl.sv
module test_smode_ctrl;
  localparam int VW = 512, PW = 64, LB = 128;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_stop = 0, cmd_sel_sm = 0, cmd_sel_za = 0, full_isa = 0;
  logic chk_valid = 0;
  logic [1:0] chk_class = 0;
  logic chk_illegal;
  logic vw_valid = 0, vw_ready;
  logic [4:0] vw_addr = 0, vr_addr = 0, lr_addr = 0;
  logic [VW-1:0] vw_data = '0, vr_data;
  logic pw_valid = 0, pw_ready;
  logic [3:0] pw_addr = 0, pr_addr = 0;
  logic [PW-1:0] pw_data = '0, pr_data;
  logic [LB-1:0] lr_data;
  logic in_stream, array_en, busy, za_zero_req;

  always #5 clk = ~clk;

  smode_ctrl i_smode_ctrl (.*);

  int errs = 0, checks = 0;
  bit done = 0;
  logic [VW-1:0] m_v [32];
  logic [PW-1:0] m_p [16];
  logic m_sm = 0, m_za = 0, m_busy = 0, m_zreq = 0;

  task automatic chk(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic exp_illegal();
    return chk_valid && ((chk_class == 2'd1 && m_sm && !full_isa) ||
                         (chk_class == 2'd3 && !m_za));
  endfunction

  task automatic check_now(string flag_tag);
    chk(flag_tag, {in_stream, array_en}, {m_sm, m_za});
    chk("R4", busy, m_busy);
    chk("R4", {vw_ready, pw_ready}, {!m_busy, !m_busy});
    chk("R10", za_zero_req, m_zreq);
    chk(chk_class == 2'd1 ? "R8" : "R9", chk_illegal, exp_illegal());
    chk(m_busy ? "R5" : "R7", vr_data, m_busy ? '0 : m_v[vr_addr]);
    chk(m_busy ? "R5" : "R7", pr_data, m_busy ? '0 : m_p[pr_addr]);
    chk(m_busy ? "R5" : "R7", lr_data, m_busy ? '0 : m_v[lr_addr][LB-1:0]);
  endtask

  // inputs are set at the falling edge, checked 2 ns later, model follows the rising edge
  task automatic cyc(string flag_tag = "R2");
    logic app_sm, app_za, tgt;
    #2;
    check_now(flag_tag);
    @(posedge clk);
    if (vw_valid && !m_busy) m_v[vw_addr] = vw_data;
    if (pw_valid && !m_busy) m_p[pw_addr] = pw_data;
    if (m_busy) begin
      for (int i = 0; i < 32; i++) m_v[i] = '0;
      for (int i = 0; i < 16; i++) m_p[i] = '0;
    end
    app_sm = cmd_sel_sm || !cmd_sel_za;
    app_za = cmd_sel_za || !cmd_sel_sm;
    tgt = !cmd_stop;
    m_busy = 0;
    m_zreq = 0;
    if (cmd_valid) begin
      if (app_sm && m_sm != tgt) m_busy = 1;
      if (app_sm) m_sm = tgt;
      if (app_za && m_za && !tgt) m_zreq = 1;
      if (app_za) m_za = tgt;
    end
    @(negedge clk);
  endtask

  task automatic idle();
    cmd_valid = 0; vw_valid = 0; pw_valid = 0;
  endtask

  task automatic command(logic stop, logic ssm, logic sza);
    cmd_valid = 1; cmd_stop = stop; cmd_sel_sm = ssm; cmd_sel_za = sza;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 32; i++) m_v[i] = '0;
    for (int i = 0; i < 16; i++) m_p[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1", {in_stream, array_en, busy, za_zero_req}, 4'b0);
    chk("R1", vr_data | lr_data | pr_data, '0);
    // R7: write vector 3 and predicate 5
    vw_valid = 1; vw_addr = 3; vw_data = {16{32'hA5A5_0001}};
    pw_valid = 1; pw_addr = 5; pw_data = 64'hDEAD_BEEF_0123_4567;
    cyc();
    idle(); vr_addr = 3; pr_addr = 5; lr_addr = 3;
    cyc();
    // R9: tile access with array disabled
    chk_valid = 1; chk_class = 2'd3;
    cyc();
    // R2: start with no selectors -> wipe
    command(0, 0, 0);
    cyc();
    idle(); chk_class = 2'd1;
    cyc("R2");          // busy cycle, reads zero (R5), legacy illegal (R8)
    cyc("R2");
    // R6: start again while streaming, data kept
    vw_valid = 1; vw_addr = 7; vw_data = {16{32'h1234_5678}};
    cyc();
    idle(); command(0, 0, 0); vr_addr = 7; lr_addr = 7;
    cyc("R6");
    idle(); full_isa = 1;
    cyc("R6");
    full_isa = 0;
    // R3: stop only the array -> zero request, streaming kept, no wipe
    command(1, 0, 1); chk_class = 2'd3;
    cyc("R3");
    idle();
    cyc("R3");
    cyc("R3");
    // R11: write during busy is dropped: stop streaming with selector
    command(1, 1, 0);
    cyc("R3");
    idle(); vw_valid = 1; vw_addr = 9; vw_data = {16{32'hFFFF_0000}}; vr_addr = 9;
    cyc("R11");
    idle();
    cyc("R11");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      cmd_valid  = ($urandom % 8) == 0;
      cmd_stop   = $urandom;
      cmd_sel_sm = $urandom;
      cmd_sel_za = $urandom;
      full_isa   = ($urandom % 4) == 0;
      chk_valid  = $urandom;
      chk_class  = $urandom;
      vw_valid   = $urandom; vw_addr = $urandom;
      for (int w = 0; w < 16; w++) vw_data[w*32 +: 32] = $urandom;
      pw_valid   = $urandom; pw_addr = $urandom;
      pw_data    = {$urandom, $urandom};
      vr_addr    = $urandom; pr_addr = $urandom; lr_addr = $urandom;
      cyc(cmd_sel_sm || cmd_sel_za ? "R3" : "R2");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule